// File: doc/BRIEF.md
# Byte-Wide Parallel EEPROM Pin-Level Emulator

This block is a clocked, synthesizable stand-in for a small byte-wide parallel EEPROM, seen from its pins. A host drives an 11-bit address, an 8-bit write bus and three active-low strobes: chip select, output gate and write strobe. The block answers with an 8-bit read bus and a bus-drive enable that a pad wrapper uses to build the bidirectional data pins. Every pin input first passes through a two-flop synchronizer. All decoding happens in the system clock domain, so the strobes may come from an asynchronous host.

A byte write is a low pulse on the write strobe. The address is taken when the strobe falls. The data, chip select and output gate are taken when it rises. A pulse that stays low for too few clocks is treated as a glitch. An accepted write runs on its own for a fixed number of clocks. During that time, a read of the byte being written shows the inverted new bit 7, and the host polls that bit until it reads true.

Two boolean inputs stand in for the high-voltage qualifiers. One maps the top 32 addresses onto a separate identification row. The other, together with chip select and write strobe held low, fills the whole main array with ones and leaves the identification row alone. Storage is a register file that holds 0xFF out of reset.

Top module: `eeprom_pin_model`

## Requirements
- R1: Each pin input reaches the logic two clock edges after it is sampled. The bus enable `data_oe_o` is 1 exactly when the synchronized chip select is low, output gate is low and write strobe is high. Otherwise it is 0.
- R2: The write address is the address present when the synchronized write strobe falls. A change of address while the strobe is low does not move the write.
- R3: A write starts at the rising strobe edge only if, at that edge, chip select is low, output gate is high and the clear qualifier is inactive. Chip select high or output gate low at that edge blocks the write.
- R4: After an accepted write of WRITE_CYCLES clocks, a read of that address returns the data present on the rising strobe edge.
- R5: A write-strobe low pulse of fewer than MIN_LOW synchronized clocks starts no write. A pulse of MIN_LOW or more clocks can start one.
- R6: A byte write replaces the whole byte, so bits at 0 can return to 1 (0xF0 overwritten with 0x0F reads 0x0F).
- R7: While a write is busy, a read of its address and row returns the inverse of the new bit 7 on bit 7, and the old stored bits 6..0. A read of any other location returns its stored data.
- R8: A write-strobe pulse that begins while a write is busy is ignored. It starts no write and does not change the address being polled.
- R9: With the signature qualifier active, addresses 0x7E0 to 0x7FF read and write a separate 32-byte identification row. With it inactive, those addresses reach the main array.
- R10: With the clear qualifier active, chip select low and write strobe low, every main-array byte becomes 0xFF. The identification row is kept, and the rising strobe that ends the clear writes nothing.
- R11: A clear request made while a write is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 11 | Address pins |
| data_i | input | 8 | Data pins as seen from the host side (write bus) |
| data_o | output | 8 | Read data towards the pads |
| data_oe_o | output | 1 | Drive enable for the data pads |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output gate, active low |
| we_n_i | input | 1 | Write strobe, active low |
| id_hv_i | input | 1 | Signature qualifier: selects the identification row at the top 32 addresses |
| clr_hv_i | input | 1 | Clear qualifier: with chip select and write strobe low, fills the main array |

## Verification
The bench probes the pulse-width limit from both sides with pulses of MIN_LOW-1 and MIN_LOW clocks. A filter that is off by one would either accept a glitch or drop a legal write.

It moves the address in the middle of a low pulse, and it raises the strobe while chip select is high or the output gate is low. A design that latched on the wrong edge would write to the second address, and one that ignored the gating would corrupt the target byte.

Polling is checked against a previously written, non-erased byte. This catches a design that shows the new data too early, or that fails to invert bit 7.

Pulses and clear requests are also issued while a write is busy. These would show a design that restarts its timer or wipes the array mid-write. Identification-row reads after a clear confirm that the clear touched only the main array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY,
        MODE_READ,
        MODE_CLEAR,
        MODE_INHIBIT
    } mode_e;

    // Pin-level mode decode from synchronized strobes
    function automatic mode_e decode_mode(input logic ce_n, input logic oe_n,
                                          input logic we_n, input logic clr_hv);
        mode_e m;
        if (ce_n)                m = MODE_STANDBY;
        else if (clr_hv && !we_n) m = MODE_CLEAR;
        else if (!oe_n && we_n)  m = MODE_READ;
        else                     m = MODE_INHIBIT;
        return m;
    endfunction

endpackage

// File: rtl/eeprom_sync.sv
module eeprom_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int ID_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_id_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_en_i,
    input  logic              rd_id_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH    = 2 ** ADDR_W;
    localparam int ID_DEPTH = 2 ** ID_W;

    logic [DATA_W-1:0] main_q [DEPTH];
    logic [DATA_W-1:0] id_q   [ID_DEPTH];

    // Main array: whole-array fill or single byte replace
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
        end else if (clr_en_i) begin
            for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
        end else if (wr_en_i && !wr_id_i) begin
            main_q[wr_addr_i] <= wr_data_i;
        end
    end

    // Identification row: untouched by the fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ID_DEPTH; i++) id_q[i] <= '1;
        end else if (wr_en_i && wr_id_i) begin
            id_q[wr_addr_i[ID_W-1:0]] <= wr_data_i;
        end
    end

    assign rd_data_o = rd_id_i ? id_q[rd_addr_i[ID_W-1:0]] : main_q[rd_addr_i];

endmodule

// File: rtl/eeprom_pin_model.sv
module eeprom_pin_model
    import eeprom_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int ID_W         = 5,
    parameter int MIN_LOW      = 4,
    parameter int WRITE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic              id_hv_i,
    input  logic              clr_hv_i
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam int LOW_W = $clog2(MIN_LOW + 1);
    localparam int PIN_W = ADDR_W + DATA_W + 5;
    localparam logic [PIN_W-1:0] PIN_RST = {2'b00, 3'b111, {(DATA_W + ADDR_W){1'b0}}};

    typedef struct packed {
        logic              we_prev;
        logic              armed;
        logic [LOW_W-1:0]  low_cnt;
        logic [ADDR_W-1:0] wr_addr;
        logic              wr_id;
        logic [DATA_W-1:0] wr_data;
        logic [CNT_W-1:0]  busy_cnt;
    } ctrl_t;

    // ---- pin synchronizer ----
    logic [PIN_W-1:0]  pins_s;
    logic              s_id, s_clr, s_ce, s_oe, s_we;
    logic [DATA_W-1:0] s_data;
    logic [ADDR_W-1:0] s_addr;

    eeprom_sync #(.W(PIN_W), .STAGES(2), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({id_hv_i, clr_hv_i, ce_n_i, oe_n_i, we_n_i, data_i, addr_i}),
        .q_o  (pins_s)
    );

    assign {s_id, s_clr, s_ce, s_oe, s_we, s_data, s_addr} = pins_s;

    function automatic logic id_hit(input logic qual, input logic [ADDR_W-1:0] a);
        return qual && (&a[ADDR_W-1:ID_W]);
    endfunction

    // ---- control ----
    ctrl_t             st_d, st_q;
    mode_e             mode;
    logic              busy, fall, rise, commit, clear_en;
    logic              rd_id;
    logic [DATA_W-1:0] rd_data;
    logic              poll_hit;

    assign mode     = decode_mode(s_ce, s_oe, s_we, s_clr);
    assign busy     = (st_q.busy_cnt != '0);
    assign fall     = st_q.we_prev && !s_we;
    assign rise     = !st_q.we_prev && s_we;
    assign commit   = (st_q.busy_cnt == CNT_W'(1));
    assign clear_en = (mode == MODE_CLEAR) && !busy;

    always_comb begin
        st_d         = st_q;
        st_d.we_prev = s_we;

        if (busy) st_d.busy_cnt = st_q.busy_cnt - CNT_W'(1);

        if (fall) begin
            st_d.armed   = !busy;
            st_d.low_cnt = LOW_W'(1);
            if (!busy) begin
                st_d.wr_addr = s_addr;
                st_d.wr_id   = id_hit(s_id, s_addr);
            end
        end else if (!s_we && st_q.armed && (st_q.low_cnt < LOW_W'(MIN_LOW))) begin
            st_d.low_cnt = st_q.low_cnt + LOW_W'(1);
        end

        if (rise) begin
            st_d.armed = 1'b0;
            if (st_q.armed && (st_q.low_cnt >= LOW_W'(MIN_LOW)) &&
                !s_ce && s_oe && !s_clr && !busy) begin
                st_d.busy_cnt = CNT_W'(WRITE_CYCLES);
                st_d.wr_data  = s_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.we_prev <= 1'b1;
        end else begin
            st_q         <= st_d;
        end
    end

    // ---- storage ----
    assign rd_id = id_hit(s_id, s_addr);

    eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (commit),
        .wr_id_i  (st_q.wr_id),
        .wr_addr_i(st_q.wr_addr),
        .wr_data_i(st_q.wr_data),
        .clr_en_i (clear_en),
        .rd_id_i  (rd_id),
        .rd_addr_i(s_addr),
        .rd_data_o(rd_data)
    );

    // ---- read path with completion polling ----
    assign poll_hit  = busy && (rd_id == st_q.wr_id) && (s_addr == st_q.wr_addr);
    assign data_oe_o = (mode == MODE_READ);
    assign data_o    = poll_hit ? {~st_q.wr_data[DATA_W-1], rd_data[DATA_W-2:0]} : rd_data;

endmodule

// File: rtl/eeprom_pin_model_chk.sv
module eeprom_pin_model_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ce,
    input logic              s_oe,
    input logic              s_we,
    input logic [ADDR_W-1:0] s_addr,
    input logic              rd_id,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_id,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  busy_cnt,
    input logic              data_oe_o,
    input logic [DATA_W-1:0] data_o
);

    // R1: bus driven only in the read condition of the synchronized strobes
    assert_read_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (!s_ce && !s_oe && s_we));

    // R3: a busy period only begins after a rising strobe with select low and gate high
    assert_write_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_cnt != '0) |-> $past(s_we && !s_ce && s_oe));

    // R8: once busy, the timer only counts down, never restarts
    assert_busy_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - CNT_W'(1)));

    // R7: polled read shows inverted new bit 7 and stored low bits
    assert_poll_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && (busy_cnt != '0) && (s_addr == wr_addr) && (rd_id == wr_id))
        |-> ((data_o[DATA_W-1] != wr_data[DATA_W-1]) &&
             (data_o[DATA_W-2:0] == rd_data[DATA_W-2:0])));

    // R4: away from the polled byte the bus carries stored data
    assert_true_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && (busy_cnt == '0)) |-> (data_o == rd_data));

endmodule

bind eeprom_pin_model eeprom_pin_model_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ce     (s_ce),
    .s_oe     (s_oe),
    .s_we     (s_we),
    .s_addr   (s_addr),
    .rd_id    (rd_id),
    .rd_data  (rd_data),
    .wr_addr  (st_q.wr_addr),
    .wr_id    (st_q.wr_id),
    .wr_data  (st_q.wr_data),
    .busy_cnt (st_q.busy_cnt),
    .data_oe_o(data_oe_o),
    .data_o   (data_o)
);

// File: tb/eeprom_pin_model_bench.sv
`timescale 1ns/1ps
module eeprom_pin_model_bench;

    localparam int MIN_LOW = 4;
    localparam int WR_CYC  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] a_addr = '0;
    logic [7:0]  a_data = '0;
    logic        a_ce = 1'b1, a_oe = 1'b1, a_we = 1'b1, a_id = 1'b0, a_clr = 1'b0;
    logic [7:0]  data_o;
    logic        data_oe_o;

    always #10 clk = ~clk;

    eeprom_pin_model #(.MIN_LOW(MIN_LOW), .WRITE_CYCLES(WR_CYC)) u_eeprom_pin_model (
        .clk(clk), .rst_n(rst_n), .addr_i(a_addr), .data_i(a_data),
        .data_o(data_o), .data_oe_o(data_oe_o), .ce_n_i(a_ce), .oe_n_i(a_oe),
        .we_n_i(a_we), .id_hv_i(a_id), .clr_hv_i(a_clr)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_main [2048];
    logic [7:0]  m_idr  [32];
    int          m_busy, m_low;
    bit          m_armed, m_weprev, m_wid;
    logic [10:0] m_waddr;
    logic [7:0]  m_wdata;
    // pin pipeline: {id, clr, ce, oe, we, data, addr}
    logic [23:0] p1, p2;

    function automatic bit is_id(bit q, logic [10:0] a);
        return q && (a[10:5] == 6'h3F);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_main[i]) m_main[i] = 8'hFF;
            foreach (m_idr[i])  m_idr[i]  = 8'hFF;
            m_busy = 0; m_low = 0; m_armed = 0; m_weprev = 1; m_wid = 0;
            m_waddr = '0; m_wdata = '0;
            p1 = {2'b00, 3'b111, 19'h0};
            p2 = p1;
        end else begin
            bit idq, clr, ce, oe, we, fall, rise, bsy;
            logic [7:0]  d;
            logic [10:0] a;
            {idq, clr, ce, oe, we, d, a} = p2;
            fall = m_weprev && !we;
            rise = !m_weprev && we;
            bsy  = (m_busy != 0);
            if (clr && !ce && !we && !bsy) foreach (m_main[i]) m_main[i] = 8'hFF;
            if (bsy) begin
                if (m_busy == 1) begin
                    if (m_wid) m_idr[m_waddr[4:0]] = m_wdata;
                    else       m_main[m_waddr]     = m_wdata;
                end
                m_busy--;
            end
            if (fall) begin
                m_armed = !bsy;
                m_low   = 1;
                if (!bsy) begin m_waddr = a; m_wid = is_id(idq, a); end
            end else if (!we && m_armed && m_low < MIN_LOW) begin
                m_low++;
            end
            if (rise) begin
                if (m_armed && m_low >= MIN_LOW && !ce && oe && !clr && !bsy) begin
                    m_busy  = WR_CYC;
                    m_wdata = d;
                end
                m_armed = 0;
            end
            m_weprev = we;
            p2 = p1;
            p1 = {a_id, a_clr, a_ce, a_oe, a_we, a_data, a_addr};
        end
    end

    // ---------------- comparison every clock ----------------
    int    n_chk = 0, n_bad = 0, n_cyc = 0;
    string cur_req = "R1";
    bit    done = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit idq, clr, ce, oe, we, exp_oe, hit;
            logic [7:0]  d, exp_d;
            logic [10:0] a;
            {idq, clr, ce, oe, we, d, a} = p2;
            exp_oe = !ce && !oe && we;
            hit    = is_id(idq, a);
            exp_d  = hit ? m_idr[a[4:0]] : m_main[a];
            if (m_busy != 0 && hit == m_wid && a == m_waddr)
                exp_d = {~m_wdata[7], exp_d[6:0]};
            n_chk++;
            if (data_oe_o !== exp_oe) begin
                n_bad++;
                $display("FAIL %s: data_oe_o actual %b expected %b (cycle %0d)",
                         cur_req, data_oe_o, exp_oe, n_cyc);
            end else if (exp_oe && data_o !== exp_d) begin
                n_bad++;
                $display("FAIL %s: data_o actual %h expected %h addr %h (cycle %0d)",
                         cur_req, data_o, exp_d, a, n_cyc);
            end
        end
        n_cyc++;
        if (n_cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [10:0] a, logic [7:0] d, bit idq, int len,
                      bit ce = 0, bit oe = 1);
        a_addr = a; a_data = d; a_id = idq; a_ce = ce; a_oe = oe; a_we = 1;
        cyc(1);
        a_we = 0;
        cyc(len);
        a_we = 1;
        cyc(2);
        a_ce = 1; a_oe = 1;
        cyc(1);
    endtask

    task automatic rd(logic [10:0] a, bit idq, int n);
        a_addr = a; a_id = idq; a_ce = 0; a_oe = 0; a_we = 1;
        cyc(n);
        a_ce = 1; a_oe = 1;
        cyc(1);
    endtask

    task automatic settle();
        cyc(WR_CYC + 8);
    endtask

    task automatic clear_pulse();
        a_ce = 0; a_oe = 1; a_clr = 1; a_we = 0;
        cyc(6);
        a_we = 1;
        cyc(3);
        a_clr = 0; a_ce = 1;
        cyc(3);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(4);

        cur_req = "R1";                      // reset contents and gating
        rd(11'h000, 0, 5);
        a_ce = 0; a_oe = 1; cyc(4);          // output gate high: no drive
        a_oe = 0; a_we = 0; cyc(4);          // strobe low: no drive
        a_we = 1; a_ce = 1; cyc(4);          // select high: standby
        a_ce = 1; a_oe = 1; cyc(2);

        cur_req = "R2";                      // address taken at falling strobe
        a_addr = 11'h0AA; a_data = 8'h5C; a_ce = 0; a_oe = 1; cyc(1);
        a_we = 0; cyc(2);
        a_addr = 11'h155; cyc(4);
        a_we = 1; cyc(2);
        a_ce = 1; cyc(1);
        settle();
        rd(11'h0AA, 0, 4);
        rd(11'h155, 0, 4);

        cur_req = "R3";                      // gating at rising strobe
        wr(11'h010, 8'h33, 0, 6, 1, 1);
        wr(11'h010, 8'h34, 0, 6, 0, 0);
        settle();
        rd(11'h010, 0, 4);

        cur_req = "R5";                      // pulse width filter
        wr(11'h020, 8'h21, 0, MIN_LOW - 1);
        settle();
        rd(11'h020, 0, 4);
        wr(11'h021, 8'h42, 0, MIN_LOW);
        settle();
        rd(11'h021, 0, 4);

        cur_req = "R4";
        wr(11'h7FF, 8'h9E, 0, 8);
        settle();
        rd(11'h7FF, 0, 4);

        cur_req = "R6";                      // full byte replacement
        wr(11'h030, 8'hF0, 0, 6);
        settle();
        wr(11'h030, 8'h0F, 0, 6);
        settle();
        rd(11'h030, 0, 4);

        cur_req = "R7";                      // polling status
        wr(11'h040, 8'h3C, 0, 6);
        settle();
        wr(11'h040, 8'hA5, 0, 6);
        rd(11'h040, 0, 10);
        rd(11'h030, 0, 4);
        rd(11'h040, 0, 30);
        settle();
        rd(11'h040, 0, 4);

        cur_req = "R8";                      // pulses during busy ignored
        wr(11'h050, 8'h11, 0, 6);
        wr(11'h051, 8'h22, 0, 6);
        rd(11'h050, 0, 6);
        rd(11'h051, 0, 4);
        settle();
        rd(11'h050, 0, 4);
        rd(11'h051, 0, 4);

        cur_req = "R9";                      // identification row
        wr(11'h7E5, 8'h77, 1, 6);
        settle();
        rd(11'h7E5, 1, 4);
        rd(11'h7E5, 0, 4);
        wr(11'h7E5, 8'h12, 0, 6);
        settle();
        rd(11'h7E5, 1, 4);
        rd(11'h7E5, 0, 4);
        wr(11'h7DF, 8'h64, 1, 6);
        settle();
        rd(11'h7DF, 0, 4);
        rd(11'h7E0, 1, 4);

        cur_req = "R10";                     // whole-array clear
        clear_pulse();
        settle();
        rd(11'h040, 0, 4);
        rd(11'h7E5, 0, 4);
        rd(11'h7E5, 1, 4);
        rd(11'h050, 0, 4);

        cur_req = "R11";                     // clear during busy ignored
        wr(11'h060, 8'h5E, 0, 6);
        settle();
        wr(11'h061, 8'h66, 0, 6);
        clear_pulse();
        settle();
        rd(11'h060, 0, 4);
        rd(11'h061, 0, 4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule